// File: doc/BRIEF.md
# Host Bus Transaction Legality Checker

This block sits on the address path of a host processor bus and judges every address tenure as it is presented. It decides whether the tenure is legal or breaks one of three rules. The first rule covers unsupported transactions: externally controlled tenures, reserved or illegal transfer-type codes, and writes into the interrupt-acknowledge window. The second covers copy-backs from the secondary cache into peripheral-bus or boot ROM space. The third covers writes into boot ROM space that the flash configuration does not permit.

The verdict appears one clock after the tenure. It consists of a one-cycle error pulse that carries a two-bit error code and the offending address, together with a termination choice for the data tenure. A violation ends with a transfer-error indication when the transfer-error enable is set, and with a normal acknowledge otherwise. A legal tenure always gets a normal acknowledge. Logging and storage of the reported errors are handled by a neighbouring block.

Top module: `hlc_top`

## Requirements
- R1: A tenure with `ext_ctl` high is reported with code 1 (unsupported).
- R2: A transfer type whose two top bits are both 1, or that equals 5'h07 or 5'h0F, is reported with code 1.
- R3: A write into the interrupt-acknowledge window is reported with code 1. With `map_b` low the window is 0xBFFFFFF0–0xBFFFFFFF. With `map_b` high it is 0xFEF00000–0xFEFFFFFF. Reads in the window, and writes just outside it, are legal.
- R4: A tenure with `l2_copyback` high is reported with code 2 when it targets boot ROM space (0xFFF00000–0xFFFFFFFF) or peripheral space. Peripheral space is 0x80000000–0xFEFFFFFF with `map_b` high, and 0x80000000–0xBFFFFFFF (parameter) with `map_b` low. Copy-backs elsewhere are legal.
- R5: A write into boot ROM space is reported with code 3 when `cfg_flash_wr_en` is low or `cfg_flash_lock` is high.
- R6: When flash writes are permitted, a ROM write is legal only if `burst` is low and `tsize` matches the data path: 0 (one byte) when `cfg_rom_narrow` is high, 3 (eight bytes) otherwise. Any other ROM write gets code 3. ROM reads never get code 3.
- R7: Only one code is reported per tenure, in the priority order code 1, then code 2, then code 3.
- R8: For a tenure presented with `tv` high in cycle N, in cycle N+1 `term_valid` is high and `err_pulse` is high exactly when a violation was found. In that same cycle `err_code` carries the code (0 = none) and `err_addr` carries the tenure address. `err_pulse` lasts one cycle.
- R9: In cycle N+1, `term_tea` is high exactly when a violation was found and `cfg_tea_en` is high. `term_ack` is high for every other tenure. The two are never high together.
- R10: While `rst` is high, and in the cycle after it, all outputs are zero.
- R11: A cycle with `tv` low produces no termination and no error pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tv | input | 1 | Address tenure valid this cycle |
| ext_ctl | input | 1 | Tenure started by external control |
| ttype | input | 5 | Transfer type code |
| addr | input | 32 | Tenure address |
| wr | input | 1 | Tenure is a write |
| burst | input | 1 | Tenure is a multi-beat burst |
| tsize | input | 3 | Transfer size, log2 of bytes |
| l2_copyback | input | 1 | Tenure is a copy-back from the secondary cache |
| map_b | input | 1 | Selects the second address map |
| cfg_flash_wr_en | input | 1 | Flash writes enabled |
| cfg_flash_lock | input | 1 | Flash write lockout |
| cfg_tea_en | input | 1 | Violations terminate with transfer error |
| cfg_rom_narrow | input | 1 | ROM data path is 8 bits wide (else 64) |
| term_valid | output | 1 | Termination decision valid |
| term_tea | output | 1 | Terminate with transfer error |
| term_ack | output | 1 | Terminate with normal acknowledge |
| err_pulse | output | 1 | Violation detected, one cycle |
| err_code | output | 2 | 0 none, 1 unsupported, 2 copy-back, 3 flash write |
| err_addr | output | 32 | Address of the violating tenure |

## Verification
A vector table presents tenures that each hit one rule alone. Each window and range is approached from both sides of its edges, so an off-by-one limit or a swapped map select shows up as a wrong code. Pairs that differ in a single input separate the flash conditions from each other: enable against lockout, burst against single beat, and narrow against wide size. Tenures that break two or three rules at once pin down the priority order. Flipping the transfer-error enable on otherwise identical tenures separates the two termination choices. Directed steps then cover reset, idle gaps and back-to-back tenures, which check pulse length and address capture.

// File: rtl/hlc_pkg.sv
package hlc_pkg;

    localparam int ADDR_W  = 32;
    localparam int TTYPE_W = 5;
    localparam int TSIZE_W = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE     = 2'd0,
        ERR_UNSUP    = 2'd1,
        ERR_COPYBACK = 2'd2,
        ERR_FLASH    = 2'd3
    } err_code_e;

    typedef struct packed {
        logic               ext;
        logic [TTYPE_W-1:0] ttype;
        logic               wr;
        logic               burst;
        logic [TSIZE_W-1:0] tsize;
        logic               cb;
        logic [ADDR_W-1:0]  addr;
    } tenure_t;

    typedef struct packed {
        logic rom;
        logic periph;
        logic iack;
    } region_t;

    localparam logic [TSIZE_W-1:0] SZ_NARROW = 3'd0;
    localparam logic [TSIZE_W-1:0] SZ_WIDE   = 3'd3;

    function automatic logic ttype_reserved(input logic [TTYPE_W-1:0] t);
        return (t[TTYPE_W-1:TTYPE_W-2] == 2'b11) || (t == 5'h07) || (t == 5'h0F);
    endfunction

    function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/hlc_region_decode.sv
module hlc_region_decode
    import hlc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROM_LO      = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] ROM_HI      = 32'hFFFF_FFFF,
    parameter logic [ADDR_W-1:0] PERIPH_A_LO = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] PERIPH_A_HI = 32'hBFFF_FFFF,
    parameter logic [ADDR_W-1:0] PERIPH_B_LO = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] PERIPH_B_HI = 32'hFEFF_FFFF,
    parameter logic [ADDR_W-1:0] IACK_A_LO   = 32'hBFFF_FFF0,
    parameter logic [ADDR_W-1:0] IACK_A_HI   = 32'hBFFF_FFFF,
    parameter logic [ADDR_W-1:0] IACK_B_LO   = 32'hFEF0_0000,
    parameter logic [ADDR_W-1:0] IACK_B_HI   = 32'hFEFF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_b,
    output region_t           region
);

    localparam int NMAP = 2;

    logic [NMAP-1:0] periph_hit;
    logic [NMAP-1:0] iack_hit;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        localparam logic [ADDR_W-1:0] P_LO = (m == 0) ? PERIPH_A_LO : PERIPH_B_LO;
        localparam logic [ADDR_W-1:0] P_HI = (m == 0) ? PERIPH_A_HI : PERIPH_B_HI;
        localparam logic [ADDR_W-1:0] I_LO = (m == 0) ? IACK_A_LO   : IACK_B_LO;
        localparam logic [ADDR_W-1:0] I_HI = (m == 0) ? IACK_A_HI   : IACK_B_HI;
        assign periph_hit[m] = in_range(addr, P_LO, P_HI);
        assign iack_hit[m]   = in_range(addr, I_LO, I_HI);
    end

    always_comb begin
        region.rom    = in_range(addr, ROM_LO, ROM_HI);
        region.periph = periph_hit[map_b];
        region.iack   = iack_hit[map_b];
    end

endmodule

// File: rtl/hlc_classify.sv
module hlc_classify
    import hlc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tv,
    input  tenure_t   ten,
    input  region_t   region,
    input  logic      flash_wr_en,
    input  logic      flash_lock,
    input  logic      rom_narrow,
    output err_code_e code
);

    logic hit_unsup;
    logic hit_cb;
    logic hit_flash;
    logic flash_allowed;
    logic flash_shape_ok;

    always_comb begin
        flash_allowed  = flash_wr_en && !flash_lock;
        flash_shape_ok = !ten.burst &&
                         (ten.tsize == (rom_narrow ? SZ_NARROW : SZ_WIDE));

        hit_unsup = ten.ext || ttype_reserved(ten.ttype) || (ten.wr && region.iack);
        hit_cb    = ten.cb && (region.rom || region.periph);
        hit_flash = ten.wr && region.rom && !(flash_allowed && flash_shape_ok);
    end

    always_comb begin
        if (hit_unsup)      code = ERR_UNSUP;
        else if (hit_cb)    code = ERR_COPYBACK;
        else if (hit_flash) code = ERR_FLASH;
        else                code = ERR_NONE;
    end

    // R7: external control always wins
    p_ext_first_r7: assert property (@(posedge clk) disable iff (rst)
        (tv && ten.ext) |-> (code == ERR_UNSUP));

    // R4: copy-back code only for copy-back tenures into a guarded region
    p_cb_region_r4: assert property (@(posedge clk) disable iff (rst)
        (tv && code == ERR_COPYBACK) |-> (ten.cb && (region.rom || region.periph)));

    // R5: flash code only for writes decoded into ROM space
    p_flash_rom_r5: assert property (@(posedge clk) disable iff (rst)
        (tv && code == ERR_FLASH) |-> (ten.wr && region.rom));

endmodule

// File: rtl/hlc_top.sv
module hlc_top
    import hlc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PERIPH_A_LO = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] PERIPH_A_HI = 32'hBFFF_FFFF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tv,
    input  logic                ext_ctl,
    input  logic [TTYPE_W-1:0]  ttype,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                burst,
    input  logic [TSIZE_W-1:0]  tsize,
    input  logic                l2_copyback,
    input  logic                map_b,
    input  logic                cfg_flash_wr_en,
    input  logic                cfg_flash_lock,
    input  logic                cfg_tea_en,
    input  logic                cfg_rom_narrow,
    output logic                term_valid,
    output logic                term_tea,
    output logic                term_ack,
    output logic                err_pulse,
    output logic [CODE_W-1:0]   err_code,
    output logic [ADDR_W-1:0]   err_addr
);

    tenure_t   ten;
    region_t   region;
    err_code_e code;
    logic      viol;

    always_comb begin
        ten.ext   = ext_ctl;
        ten.ttype = ttype;
        ten.wr    = wr;
        ten.burst = burst;
        ten.tsize = tsize;
        ten.cb    = l2_copyback;
        ten.addr  = addr;
    end

    hlc_region_decode #(
        .PERIPH_A_LO (PERIPH_A_LO),
        .PERIPH_A_HI (PERIPH_A_HI)
    ) u_decode (
        .addr   (addr),
        .map_b  (map_b),
        .region (region)
    );

    hlc_classify u_classify (
        .clk         (clk),
        .rst         (rst),
        .tv          (tv),
        .ten         (ten),
        .region      (region),
        .flash_wr_en (cfg_flash_wr_en),
        .flash_lock  (cfg_flash_lock),
        .rom_narrow  (cfg_rom_narrow),
        .code        (code)
    );

    assign viol = (code != ERR_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            term_valid <= 1'b0;
            term_tea   <= 1'b0;
            term_ack   <= 1'b0;
            err_pulse  <= 1'b0;
            err_code   <= ERR_NONE;
            err_addr   <= '0;
        end else begin
            term_valid <= tv;
            term_tea   <= tv && viol && cfg_tea_en;
            term_ack   <= tv && !(viol && cfg_tea_en);
            err_pulse  <= tv && viol;
            err_code   <= tv ? code : ERR_NONE;
            if (tv && viol) err_addr <= ten.addr;
        end
    end

    // R8: every tenure gets a termination in the next cycle
    p_term_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst && tv) |=> term_valid);

    // R11: idle cycles produce nothing
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!rst && !tv) |=> (!term_valid && !err_pulse));

    // R9: exactly one termination kind when valid
    p_term_kind_r9: assert property (@(posedge clk) disable iff (rst)
        term_valid |-> ($onehot0({term_tea, term_ack}) && (term_tea || term_ack)));

    // R9: transfer error only for a violation
    p_tea_needs_err_r9: assert property (@(posedge clk) disable iff (rst)
        term_tea |-> err_pulse);

    // R8: the pulse carries a nonzero code and the tenure address
    p_pulse_code_r8: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_code != ERR_NONE));

    p_pulse_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst && tv) |=> (!err_pulse || err_addr == $past(addr)));

endmodule

// File: tb/hlc_top_tb.sv
module hlc_top_tb;

    typedef struct packed {
        logic [3:0]  rq;
        logic        ext;
        logic [4:0]  tt;
        logic [31:0] a;
        logic        wr;
        logic        bu;
        logic [2:0]  sz;
        logic        cb;
        logic        mb;
        logic        fe;
        logic        fl;
        logic        te;
        logic        na;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 27;
    // fields: rq ext tt addr wr burst size cb map_b fen lock tea narrow expected
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd8,  1'b0, 5'h0A, 32'h0000_1000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R8 legal read
        '{4'd1,  1'b1, 5'h0A, 32'h0000_1000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R1
        '{4'd2,  1'b0, 5'h18, 32'h0000_2000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1}, // R2 top bits 11
        '{4'd2,  1'b0, 5'h07, 32'h0000_2000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R2 07
        '{4'd2,  1'b0, 5'h0F, 32'h0000_2000, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R2 0F
        '{4'd2,  1'b0, 5'h17, 32'h0000_2000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R2 legal 17
        '{4'd3,  1'b0, 5'h02, 32'hBFFF_FFF4, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R3 map A write
        '{4'd3,  1'b0, 5'h0A, 32'hBFFF_FFF4, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 map A read
        '{4'd3,  1'b0, 5'h02, 32'hBFFF_FFEF, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 below window
        '{4'd3,  1'b0, 5'h02, 32'hFEF0_0000, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1}, // R3 map B low
        '{4'd3,  1'b0, 5'h02, 32'hFEFF_FFFF, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R3 map B high
        '{4'd3,  1'b0, 5'h02, 32'hFEEF_FFFF, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 map B below
        '{4'd3,  1'b0, 5'h02, 32'hFEF0_0000, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R3 map swapped
        '{4'd4,  1'b0, 5'h06, 32'h8000_0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2}, // R4 periph B
        '{4'd4,  1'b0, 5'h06, 32'h1000_0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R4 memory
        '{4'd4,  1'b0, 5'h06, 32'hFFF0_0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2}, // R4 rom
        '{4'd4,  1'b0, 5'h06, 32'hC000_0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // R4 map A outside
        '{4'd4,  1'b0, 5'h06, 32'hC000_0000, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2}, // R4 map B inside
        '{4'd5,  1'b0, 5'h02, 32'hFFF0_0010, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3}, // R5 not enabled
        '{4'd5,  1'b0, 5'h02, 32'hFFFF_FFF8, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3}, // R5 locked
        '{4'd6,  1'b0, 5'h02, 32'hFFF0_0008, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0}, // R6 wide ok
        '{4'd6,  1'b0, 5'h02, 32'hFFF0_0008, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3}, // R6 burst
        '{4'd6,  1'b0, 5'h02, 32'hFFF0_0001, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3}, // R6 narrow size bad
        '{4'd6,  1'b0, 5'h02, 32'hFFF0_0001, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0}, // R6 narrow ok
        '{4'd6,  1'b0, 5'h0A, 32'hFFF0_0000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R6 rom read
        '{4'd7,  1'b1, 5'h06, 32'hFFF0_0000, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R7 all three
        '{4'd7,  1'b0, 5'h06, 32'hFFF0_0040, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2}  // R7 cb over flash
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        tv, ext_ctl, wr, burst, l2_copyback, map_b;
    logic        cfg_flash_wr_en, cfg_flash_lock, cfg_tea_en, cfg_rom_narrow;
    logic [4:0]  ttype;
    logic [31:0] addr;
    logic [2:0]  tsize;
    logic        term_valid, term_tea, term_ack, err_pulse;
    logic [1:0]  err_code;
    logic [31:0] err_addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    hlc_top u_dut (
        .clk(clk), .rst(rst), .tv(tv), .ext_ctl(ext_ctl), .ttype(ttype),
        .addr(addr), .wr(wr), .burst(burst), .tsize(tsize),
        .l2_copyback(l2_copyback), .map_b(map_b),
        .cfg_flash_wr_en(cfg_flash_wr_en), .cfg_flash_lock(cfg_flash_lock),
        .cfg_tea_en(cfg_tea_en), .cfg_rom_narrow(cfg_rom_narrow),
        .term_valid(term_valid), .term_tea(term_tea), .term_ack(term_ack),
        .err_pulse(err_pulse), .err_code(err_code), .err_addr(err_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        tv = 1'b1; ext_ctl = v.ext; ttype = v.tt; addr = v.a; wr = v.wr;
        burst = v.bu; tsize = v.sz; l2_copyback = v.cb; map_b = v.mb;
        cfg_flash_wr_en = v.fe; cfg_flash_lock = v.fl; cfg_tea_en = v.te;
        cfg_rom_narrow = v.na;
    endtask

    task automatic idle();
        tv = 1'b0; ext_ctl = 1'b0; ttype = 5'h0A; addr = 32'h0; wr = 1'b0;
        burst = 1'b0; tsize = 3'd3; l2_copyback = 1'b0;
    endtask

    task automatic expect_result(input string req, input vec_t v);
        logic bad;
        bad = (v.exp != 2'd0);
        check(req, "term_valid", {31'b0, term_valid}, 32'd1);
        check(req, "err_pulse",  {31'b0, err_pulse},  {31'b0, bad});
        check(req, "err_code",   {30'b0, err_code},   {30'b0, v.exp});
        if (bad) check(req, "err_addr", err_addr, v.a);
        check("R9", "term_tea", {31'b0, term_tea}, {31'b0, bad && v.te});
        check("R9", "term_ack", {31'b0, term_ack}, {31'b0, !(bad && v.te)});
    endtask

    task automatic expect_quiet(input string req);
        check(req, "term_valid", {31'b0, term_valid}, 32'd0);
        check(req, "term_tea",   {31'b0, term_tea},   32'd0);
        check(req, "term_ack",   {31'b0, term_ack},   32'd0);
        check(req, "err_pulse",  {31'b0, err_pulse},  32'd0);
        check(req, "err_code",   {30'b0, err_code},   32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        map_b = 1'b0; cfg_flash_wr_en = 1'b0; cfg_flash_lock = 1'b0;
        cfg_tea_en = 1'b0; cfg_rom_narrow = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        // R10: reset state
        expect_quiet("R10");
        check("R10", "err_addr", err_addr, 32'd0);

        // R10: tenure during reset is dropped
        drive(VECS[1]);
        @(negedge clk);
        expect_quiet("R10");
        rst = 1'b0;
        idle();
        @(negedge clk);
        expect_quiet("R10");

        // table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].rq);
            drive(VECS[i]);
            @(negedge clk);
            idle();
            expect_result(tag, VECS[i]);
        end

        // R11: idle cycle after a violation is quiet, pulse is one cycle
        drive(VECS[1]);
        @(negedge clk);
        idle();
        expect_result("R8", VECS[1]);
        @(negedge clk);
        expect_quiet("R11");
        check("R8", "err_addr held", err_addr, VECS[1].a);

        // R8: back-to-back tenures, error then legal then error
        drive(VECS[18]);
        @(negedge clk);
        drive(VECS[0]);
        expect_result("R8", VECS[18]);
        @(negedge clk);
        drive(VECS[13]);
        expect_result("R8", VECS[0]);
        @(negedge clk);
        idle();
        expect_result("R8", VECS[13]);

        // R9: same violation with transfer-error enable toggled
        begin
            vec_t v;
            v = VECS[6];
            v.te = 1'b0;
            drive(v);
            @(negedge clk);
            idle();
            expect_result("R9", v);
            v.te = 1'b1;
            drive(v);
            @(negedge clk);
            idle();
            expect_result("R9", v);
        end

        // R11: long idle stretch
        repeat (4) begin
            @(negedge clk);
            expect_quiet("R11");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule